// File: doc/BRIEF.md
# Binary and Packed-BCD Add/Subtract Unit

This block is the arithmetic core of an 8-bit accumulator datapath. It adds with carry or subtracts with borrow. Each operation runs either on plain binary bytes or on two packed decimal digits per byte. The flag outputs follow the exact conventions of a classic 8-bit processor, including the quirky flags of decimal mode. In decimal addition, the zero flag comes from the raw binary sum. The sign and overflow flags come from an intermediate value whose low digit has been adjusted but whose high digit has not. Decimal subtraction reports the binary flags and corrects only the result byte.

The surrounding datapath supplies the accumulator, the operand, the incoming carry, the decimal-mode flag and an add/subtract select. It receives the result byte and the sign, zero, overflow and carry flags. The arithmetic itself is combinational. A parameter places an output register behind it, reset to all zeros, or bypasses the register. Digits above 9 are not rejected. They go through the same correction steps and give a fixed, repeatable answer.

Top module: `bcdalu_unit`

## Requirements
- R1: With decimal mode clear and sub_i=0, {carry_o, result_o} equals acc_i + opnd_i + carry_i as a 9-bit sum.
- R2: In binary add, neg_o is result bit 7 and zero_o is set when the result is 0x00. ovf_o is bit 7 of (~(acc^opnd) & (acc^result)).
- R3: With decimal mode clear and sub_i=1, result_o is the low byte of acc_i - opnd_i - 1 + carry_i. carry_o is 1 exactly when that difference is not negative.
- R4: In binary subtract, neg_o and zero_o come from the result byte. ovf_o is bit 7 of ((acc^opnd) & (acc^result)).
- R5: In decimal add, L = acc[3:0] + opnd[3:0] + carry_i. When L >= 10, the 9-bit binary sum gains 6 if L < 26 and loses 10 otherwise. This gives the intermediate T.
- R6: In decimal add, zero_o is set exactly when the low byte of the uncorrected binary sum is 0x00.
- R7: In decimal add, neg_o is bit 7 of T. ovf_o is bit 7 of (~(acc^opnd) & (acc^T)).
- R8: In decimal add, if T >= 0xA0 then carry_o=1 and result_o=(T+0x60) mod 256. Otherwise carry_o=0 and result_o is the low byte of T.
- R9: In decimal subtract, neg_o, zero_o, ovf_o and carry_o equal the values the binary subtract gives for the same inputs.
- R10: In decimal subtract, D = acc[3:0] - opnd[3:0] - 1 + carry_i. If D < 0, the binary result gains 10 when D < -10 and loses 6 otherwise. If the binary carry is 0, a further 0x60 is taken off, all modulo 256.
- R11: With REG_OUT=1, every output shows the function of the inputs sampled at the previous rising clock edge and holds between edges. While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry in (1 = no borrow when subtracting) |
| dec_mode_i | input | 1 | 1 selects packed-BCD arithmetic |
| sub_i | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| result_o | output | 8 | Result byte |
| neg_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Signed overflow flag |
| carry_o | output | 1 | Carry out / no-borrow flag |

## Verification
Random operand pairs over the full byte range exercise all four mode combinations. In that range, digits above 9 test the deterministic handling of invalid BCD. A second random stream keeps every digit valid. It separates the normal decimal adjustments from the wrap cases, such as L of 26 or more and D below -10. Directed pairs aim at the edges where the flags part ways: 0x99+0x01 gives a zero result with the zero flag clear, 0x00-0x01 borrows through both digits, and 0x7F+0x01 sets binary overflow. A vector change sampled between clock edges shows that the registered outputs wait for the edge.

// File: rtl/bcdalu_pkg.sv
`timescale 1ns/1ps
package bcdalu_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIG_W   = 4;
  localparam int WIDE_W  = BYTE_W + 2;
  localparam int LDIG_W  = DIG_W + 1;
  localparam int SDIG_W  = DIG_W + 2;

  localparam logic [LDIG_W-1:0] DIG_TEN   = LDIG_W'(10);
  localparam logic [LDIG_W-1:0] DIG_WRAP  = LDIG_W'(26);
  localparam logic [WIDE_W-1:0] HI_LIMIT  = WIDE_W'(8'hA0);
  localparam logic [BYTE_W-1:0] HI_FIX    = 8'h60;
  localparam logic [BYTE_W-1:0] LO_FIX_UP = 8'h0A;
  localparam logic [BYTE_W-1:0] LO_FIX_DN = 8'hFA;
  // -10 written as an unsigned SDIG_W-bit code
  localparam logic [SDIG_W-1:0] SDIG_M10  = SDIG_W'(54);

  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              n;
    logic              z;
    logic              v;
    logic              c;
  } alu_word_t;

  function automatic logic ovf_of_add(input logic [BYTE_W-1:0] a,
                                      input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-1:0] r);
    logic [BYTE_W-1:0] t;
    t = ~(a ^ b) & (a ^ r);
    return t[BYTE_W-1];
  endfunction

  function automatic logic ovf_of_sub(input logic [BYTE_W-1:0] a,
                                      input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-1:0] r);
    logic [BYTE_W-1:0] t;
    t = (a ^ b) & (a ^ r);
    return t[BYTE_W-1];
  endfunction

  function automatic logic [LDIG_W-1:0] low_digit_sum(input logic [DIG_W-1:0] a,
                                                      input logic [DIG_W-1:0] b,
                                                      input logic cin);
    return {1'b0, a} + {1'b0, b} + {{DIG_W{1'b0}}, cin};
  endfunction

  // two's-complement SDIG_W-bit result, MSB is the sign
  function automatic logic [SDIG_W-1:0] low_digit_diff(input logic [DIG_W-1:0] a,
                                                       input logic [DIG_W-1:0] b,
                                                       input logic cin);
    return {2'b00, a} - {2'b00, b} + {{(SDIG_W-1){1'b0}}, cin} - SDIG_W'(1);
  endfunction
endpackage

// File: rtl/bcdalu_bin_core.sv
`timescale 1ns/1ps
module bcdalu_bin_core
  import bcdalu_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [BYTE_W:0]   raw_o,
  output alu_word_t         word_o
);
  logic [BYTE_W-1:0] b_eff;

  // one carry chain: subtraction adds the inverted operand
  assign b_eff = sub_i ? ~b_i : b_i;
  assign raw_o = {1'b0, a_i} + {1'b0, b_eff} + {{BYTE_W{1'b0}}, cin_i};

  always_comb begin
    word_o.res = raw_o[BYTE_W-1:0];
    word_o.c   = raw_o[BYTE_W];
    word_o.n   = raw_o[BYTE_W-1];
    word_o.z   = ~|raw_o[BYTE_W-1:0];
    word_o.v   = sub_i ? ovf_of_sub(a_i, b_i, raw_o[BYTE_W-1:0])
                       : ovf_of_add(a_i, b_i, raw_o[BYTE_W-1:0]);
  end
endmodule

// File: rtl/bcdalu_dec_adjust.sv
`timescale 1ns/1ps
module bcdalu_dec_adjust
  import bcdalu_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  input  logic [BYTE_W:0]   raw_i,
  input  alu_word_t         bin_i,
  output logic [WIDE_W-1:0] wide_o,
  output alu_word_t         word_o
);
  logic [LDIG_W-1:0] lo_add;
  logic [SDIG_W-1:0] lo_sub;
  logic              lo_neg, lo_deep;
  alu_word_t         add_w, sub_w;
  logic [BYTE_W-1:0] sub_res;

  assign lo_add  = low_digit_sum(a_i[DIG_W-1:0], b_i[DIG_W-1:0], cin_i);
  assign lo_sub  = low_digit_diff(a_i[DIG_W-1:0], b_i[DIG_W-1:0], cin_i);
  assign lo_neg  = lo_sub[SDIG_W-1];
  assign lo_deep = lo_neg && (lo_sub < SDIG_M10);

  // addition: low-digit fix on the wide sum, then the high-digit fix
  always_comb begin
    wide_o = {1'b0, raw_i};
    if (lo_add >= DIG_TEN)
      wide_o = (lo_add < DIG_WRAP) ? wide_o + WIDE_W'(6) : wide_o - WIDE_W'(10);
    add_w.z = ~|raw_i[BYTE_W-1:0];
    add_w.n = wide_o[BYTE_W-1];
    add_w.v = ovf_of_add(a_i, b_i, wide_o[BYTE_W-1:0]);
    if (wide_o >= HI_LIMIT) begin
      add_w.c   = 1'b1;
      add_w.res = wide_o[BYTE_W-1:0] + HI_FIX;
    end else begin
      add_w.c   = 1'b0;
      add_w.res = wide_o[BYTE_W-1:0];
    end
  end

  // subtraction: flags stay binary, only the byte is corrected
  always_comb begin
    sub_res = bin_i.res;
    if (lo_neg)
      sub_res = sub_res + (lo_deep ? LO_FIX_UP : LO_FIX_DN);
    if (!bin_i.c)
      sub_res = sub_res - HI_FIX;
    sub_w     = bin_i;
    sub_w.res = sub_res;
  end

  assign word_o = sub_i ? sub_w : add_w;
endmodule

// File: rtl/bcdalu_out_stage.sv
`timescale 1ns/1ps
module bcdalu_out_stage
  import bcdalu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  alu_word_t d_i,
  output alu_word_t q_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
      end

      // R11
      reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_o == $past(d_i)));
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/bcdalu_unit.sv
`timescale 1ns/1ps
module bcdalu_unit
  import bcdalu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] opnd_i,
  input  logic              carry_i,
  input  logic              dec_mode_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] result_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              ovf_o,
  output logic              carry_o
);
  logic [BYTE_W:0]   bin_raw;
  logic [WIDE_W-1:0] dec_wide;
  alu_word_t         bin_w, dec_w, next_w, held_w;

  bcdalu_bin_core u_bin (
    .a_i(acc_i), .b_i(opnd_i), .cin_i(carry_i), .sub_i(sub_i),
    .raw_o(bin_raw), .word_o(bin_w)
  );

  bcdalu_dec_adjust u_dec (
    .a_i(acc_i), .b_i(opnd_i), .cin_i(carry_i), .sub_i(sub_i),
    .raw_i(bin_raw), .bin_i(bin_w), .wide_o(dec_wide), .word_o(dec_w)
  );

  assign next_w = dec_mode_i ? dec_w : bin_w;

  bcdalu_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .d_i(next_w), .q_o(held_w)
  );

  assign result_o = held_w.res;
  assign neg_o    = held_w.n;
  assign zero_o   = held_w.z;
  assign ovf_o    = held_w.v;
  assign carry_o  = held_w.c;

  // R1
  bin_add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_mode_i && !sub_i) |->
      ({next_w.c, next_w.res} == ({1'b0, acc_i} + {1'b0, opnd_i} + {{BYTE_W{1'b0}}, carry_i})));

  // R3
  bin_sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_mode_i && sub_i) |->
      (next_w.c == (({1'b0, acc_i} + {{BYTE_W{1'b0}}, carry_i}) > {1'b0, opnd_i})));

  // R6
  dec_add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode_i && !sub_i) |->
      (next_w.z == (BYTE_W'(acc_i + opnd_i + {{(BYTE_W-1){1'b0}}, carry_i}) == '0)));

  // R8
  dec_add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode_i && !sub_i) |-> (next_w.c == (dec_wide >= HI_LIMIT)));

  // R9
  dec_sub_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode_i && sub_i) |->
      ({next_w.n, next_w.z, next_w.v, next_w.c} == {bin_w.n, bin_w.z, bin_w.v, bin_w.c}));
endmodule

// File: tb/bcdalu_unit_bench.sv
`timescale 1ns/1ps
module bcdalu_unit_bench;
  localparam time CLK_P = 20ns;
  localparam int  N_RAND = 40000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc = '0, opnd = '0;
  logic       cin = 1'b0, dec = 1'b0, sub = 1'b0;
  logic [7:0] res;
  logic       n_f, z_f, v_f, c_f;
  int         total = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  bcdalu_unit u_bcdalu_unit (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .opnd_i(opnd), .carry_i(cin),
    .dec_mode_i(dec), .sub_i(sub), .result_o(res), .neg_o(n_f),
    .zero_o(z_f), .ovf_o(v_f), .carry_o(c_f)
  );

  // reference: {res[7:0], n, z, v, c}
  function automatic logic [11:0] model(int a, int b, int ci, bit d, bit s);
    int sum, lo, t, r, n, z, v, c;
    if (!s) begin
      sum = a + b + ci;
      z = ((sum % 256) == 0);
      if (!d) begin
        r = sum % 256; c = sum / 256; n = r / 128;
        v = ((~(a ^ b) & (a ^ r)) >> 7) & 1;
      end else begin
        lo = a % 16 + b % 16 + ci;
        t = sum;
        if (lo >= 10) t = (lo < 26) ? t + 6 : t - 10;
        n = (t >> 7) & 1;
        v = ((~(a ^ b) & (a ^ t)) >> 7) & 1;
        if (t >= 160) begin c = 1; r = (t + 96) % 256; end
        else begin c = 0; r = t % 256; end
      end
    end else begin
      sum = a - b - 1 + ci;
      c = (sum >= 0) ? 1 : 0;
      r = (sum + 256) % 256;
      n = r / 128; z = (r == 0);
      v = (((a ^ b) & (a ^ r)) >> 7) & 1;
      if (d) begin
        lo = a % 16 - b % 16 - 1 + ci;
        if (lo < 0) r = (lo < -10) ? r + 10 : r - 6;
        if (c == 0) r = r - 96;
        r = (r + 512) % 256;
      end
    end
    return {r[7:0], n[0], z[0], v[0], c[0]};
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [7:0] a, input logic [7:0] b,
                         input bit ci, input bit d, input bit s);
    logic [11:0] e;
    int idx;
    string t_res[4] = '{"R1", "R3", "R5", "R10"};
    string t_c[4]   = '{"R1", "R3", "R8", "R9"};
    string t_nv[4]  = '{"R2", "R4", "R7", "R9"};
    string t_z[4]   = '{"R2", "R4", "R6", "R9"};
    @(negedge clk);
    acc = a; opnd = b; cin = ci; dec = d; sub = s;
    e = model(int'(a), int'(b), int'(ci), d, s);
    idx = {30'd0, d, s};
    @(posedge clk); #5;
    cmp(t_res[idx], "result", res, e[11:4]);
    cmp(t_nv[idx], "neg", {7'd0, n_f}, {7'd0, e[3]});
    cmp(t_z[idx], "zero", {7'd0, z_f}, {7'd0, e[2]});
    cmp(t_nv[idx], "ovf", {7'd0, v_f}, {7'd0, e[1]});
    cmp(t_c[idx], "carry", {7'd0, c_f}, {7'd0, e[0]});
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd7151);
    acc = 8'h55; opnd = 8'h33; cin = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    // R11 outputs stay zero under reset
    cmp("R11", "reset result", res, 8'h00);
    cmp("R11", "reset flags", {4'd0, n_f, z_f, v_f, c_f}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R11 registered latency: output holds until the edge
    run_vec(8'h10, 8'h20, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    acc = 8'h01; opnd = 8'h01;
    #2 cmp("R11", "held before edge", res, 8'h30);
    @(posedge clk); #5 cmp("R11", "after edge", res, 8'h02);

    // directed corners
    run_vec(8'h7F, 8'h01, 1'b0, 1'b0, 1'b0); // R2 overflow
    run_vec(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0); // R1 carry out, zero
    run_vec(8'h00, 8'h01, 1'b1, 1'b0, 1'b1); // R3 borrow
    run_vec(8'h80, 8'h01, 1'b1, 1'b0, 1'b1); // R4 overflow
    run_vec(8'h09, 8'h01, 1'b0, 1'b1, 1'b0); // R5 digit carry
    run_vec(8'h99, 8'h01, 1'b0, 1'b1, 1'b0); // R6 R8 zero result, Z clear
    run_vec(8'h0F, 8'h0F, 1'b1, 1'b1, 1'b0); // R5 wrap path L >= 26
    run_vec(8'h79, 8'h01, 1'b0, 1'b1, 1'b0); // R7 sign from intermediate
    run_vec(8'h00, 8'h01, 1'b1, 1'b1, 1'b1); // R10 double borrow
    run_vec(8'h00, 8'h0F, 1'b0, 1'b1, 1'b1); // R10 D < -10
    run_vec(8'h50, 8'h01, 1'b1, 1'b1, 1'b1); // R9 R10

    for (int i = 0; i < N_RAND; i++) begin
      logic [7:0] a, b;
      if (i % 2 == 0) begin
        a = 8'($urandom); b = 8'($urandom);
      end else begin
        a = {4'($urandom % 10), 4'($urandom % 10)};
        b = {4'($urandom % 10), 4'($urandom % 10)};
      end
      run_vec(a, b, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule